// File: doc/BRIEF.md
# Sequential Pairwise-Elimination Linear SVM Classifier

This block sorts a vector of signed fixed-point features into one of several classes using a set of pairwise linear SVM decisions. It has a single multiply-accumulate engine. That engine is reused for every pairwise decision and handles one feature-weight product per clock. Each class pair has a weight vector and a bias, held as fixed constants in a small parameter store. A control unit keeps track of the two candidate classes still in contention. It addresses the store for that pair and, once the score is known, drops one candidate according to the score's sign.

Because one class is dropped at every decision, a K-class problem needs only K-1 pairwise evaluations rather than all K(K-1)/2. Each evaluation takes one cycle per feature plus one cycle that adds the bias and records the decision. With the default four classes and six features, a classification therefore takes 21 cycles. The surrounding logic presents a feature vector and pulses start. It then waits for the one-cycle done pulse and reads the class index, which stays valid until the next result replaces it.

Top module: `svm_dag_classifier`

## Requirements
- R1: `done_o` rises exactly (N_CLASS-1)*(N_FEAT+1) rising edges after the edge that accepts `start_i`. This is 21 edges for 4 classes and 6 features.
- R2: Pairs (a,b) with a<b are numbered in lexicographic order (0,1),(0,2),…,(0,K-1),(1,2),…; pair p has weight w(p,f) = ((37p + 23f + 11) mod 256) - 128 for feature f, and bias ((97p + 13) mod 256 - 128) * 64.
- R3: The candidates start as low=0 and high=K-1. Each decision computes score = bias + Σ x[f]*w(p,f) for the current pair (low,high). A score of zero or more drops the high class (high decreases by one); a negative score drops the low class (low increases by one). The result is the one class left.
- R4: Exactly K-1 pairwise decisions are made per classification, one decision per (N_FEAT+1)-cycle node.
- R5: `done_o` is high for exactly one cycle per classification.
- R6: `class_o` changes only in the cycle where `done_o` is high, and it holds that value until the next result.
- R7: The accumulator holds every product sum plus bias without wrapping, including all-maximum and all-minimum feature vectors.
- R8: A `start_i` pulse that arrives while a classification is running is ignored. The running result and its timing are unaffected.
- R9: Features are taken from `feat_i` (feature f in bits [f*FEAT_W +: FEAT_W], two's complement) at the edge that accepts start. Later changes to `feat_i` do not affect that result.
- R10: A `start_i` that is high in the same cycle as `done_o` is accepted, so classifications can run back to back.
- R11: After reset, `done_o` is 0 and `class_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| feat_i | input | N_FEAT*FEAT_W | Packed signed feature vector |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| class_o | output | $clog2(N_CLASS) | Predicted class index, held between results |

## Verification
Two functions of the block can fall in the same cycle. The first is the final decision, which raises `done_o` and loads `class_o`. The second is the acceptance of a new start, which captures features and clears the accumulator. The bench drives `start_i` in the very cycle in which `done_o` is seen high. It judges the outcome by checking that the first result stays on `class_o` for the full second run and that the second result arrives exactly 21 edges later with the class the reference model predicts. Separately, starts and feature changes injected in the middle of a run must leave both the latency and the class unchanged.

// File: rtl/svm_dag_pkg.sv
package svm_dag_pkg;

  localparam int unsigned DEF_CLASSES = 4;
  localparam int unsigned DEF_FEATS   = 6;
  localparam int unsigned DEF_FEAT_W  = 8;
  localparam int unsigned DEF_WGT_W   = 8;
  localparam int unsigned DEF_BIAS_W  = 16;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_MAC    = 2'd1,
    ST_DECIDE = 2'd2
  } ctl_state_e;

  // Lexicographic slot of pair (lo,hi), lo<hi, among k classes.
  function automatic int pair_slot(int lo, int hi, int k);
    return lo * k - (lo * (lo + 1)) / 2 + (hi - lo - 1);
  endfunction

  // Fixed model constants, generated arithmetically.
  function automatic int weight_val(int p, int f);
    return ((p * 37 + f * 23 + 11) % 256) - 128;
  endfunction

  function automatic int bias_val(int p);
    return (((p * 97 + 13) % 256) - 128) * 64;
  endfunction

  function automatic int acc_width(int feat_w, int wgt_w, int n_feat);
    return feat_w + wgt_w + $clog2(n_feat + 1);
  endfunction

endpackage

// File: rtl/svm_param_rom.sv
module svm_param_rom #(
  parameter int unsigned N_CLASS = 4,
  parameter int unsigned N_FEAT  = 6,
  parameter int unsigned WGT_W   = 8,
  parameter int unsigned BIAS_W  = 16,
  parameter int unsigned PAIR_W  = 3,
  parameter int unsigned FIDX_W  = 3
) (
  input  logic [PAIR_W-1:0]        pair_idx_i,
  input  logic [FIDX_W-1:0]        feat_idx_i,
  output logic signed [WGT_W-1:0]  wgt_o,
  output logic signed [BIAS_W-1:0] bias_o
);
  localparam int unsigned NPAIR = N_CLASS * (N_CLASS - 1) / 2;
  localparam int unsigned NWGT  = NPAIR * N_FEAT;

  logic signed [WGT_W-1:0]  wtab [NWGT];
  logic signed [BIAS_W-1:0] btab [NPAIR];

  for (genvar gp = 0; gp < NPAIR; gp++) begin : g_pair
    assign btab[gp] = BIAS_W'(svm_dag_pkg::bias_val(gp));
    for (genvar gf = 0; gf < N_FEAT; gf++) begin : g_feat
      assign wtab[gp*N_FEAT+gf] = WGT_W'(svm_dag_pkg::weight_val(gp, gf));
    end
  end

  always_comb begin
    int widx;
    widx = int'(pair_idx_i) * N_FEAT + int'(feat_idx_i);
    wgt_o  = '0;
    bias_o = '0;
    if (widx < NWGT)               wgt_o  = wtab[widx];
    if (int'(pair_idx_i) < NPAIR)  bias_o = btab[pair_idx_i];
  end
endmodule

// File: rtl/svm_mac.sv
module svm_mac #(
  parameter int unsigned FEAT_W = 8,
  parameter int unsigned WGT_W  = 8,
  parameter int unsigned BIAS_W = 16,
  parameter int unsigned ACC_W  = 19
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear_i,
  input  logic                     mac_en_i,
  input  logic signed [FEAT_W-1:0] feat_i,
  input  logic signed [WGT_W-1:0]  wgt_i,
  input  logic signed [BIAS_W-1:0] bias_i,
  output logic signed [ACC_W-1:0]  acc_o,
  output logic signed [ACC_W-1:0]  score_o,
  output logic                     score_neg_o
);
  localparam int unsigned PROD_W = FEAT_W + WGT_W;

  logic signed [PROD_W-1:0] prod_w;
  logic signed [ACC_W-1:0]  prod_ext_w;
  logic signed [ACC_W-1:0]  bias_ext_w;
  logic signed [ACC_W-1:0]  acc_q;

  assign prod_w     = feat_i * wgt_i;
  assign prod_ext_w = {{(ACC_W-PROD_W){prod_w[PROD_W-1]}}, prod_w};
  assign bias_ext_w = {{(ACC_W-BIAS_W){bias_i[BIAS_W-1]}}, bias_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (clear_i)  acc_q <= '0;
    else if (mac_en_i) acc_q <= acc_q + prod_ext_w;
  end

  assign acc_o       = acc_q;
  assign score_o     = acc_q + bias_ext_w;
  assign score_neg_o = score_o[ACC_W-1];
endmodule

// File: rtl/svm_dag_ctrl.sv
module svm_dag_ctrl #(
  parameter int unsigned N_CLASS = 4,
  parameter int unsigned N_FEAT  = 6,
  parameter int unsigned CLS_W   = 2,
  parameter int unsigned PAIR_W  = 3,
  parameter int unsigned FIDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              score_neg_i,
  output logic              busy_o,
  output logic              capture_o,
  output logic              clear_o,
  output logic              mac_en_o,
  output logic              decide_o,
  output logic [FIDX_W-1:0] feat_idx_o,
  output logic [PAIR_W-1:0] pair_idx_o,
  output logic [CLS_W-1:0]  lo_o,
  output logic [CLS_W-1:0]  hi_o,
  output logic              done_o,
  output logic [CLS_W-1:0]  class_o
);
  import svm_dag_pkg::*;

  localparam logic [FIDX_W-1:0] LAST_FEAT = FIDX_W'(N_FEAT - 1);
  localparam logic [CLS_W-1:0]  TOP_CLASS = CLS_W'(N_CLASS - 1);

  ctl_state_e        state_q;
  logic [FIDX_W-1:0] fidx_q;
  logic [CLS_W-1:0]  lo_q, hi_q;
  logic              done_q;
  logic [CLS_W-1:0]  class_q;
  logic              last_node_w;
  logic [CLS_W-1:0]  survivor_w;

  assign busy_o    = (state_q != ST_IDLE);
  assign capture_o = (state_q == ST_IDLE) && start_i;
  assign mac_en_o  = (state_q == ST_MAC);
  assign decide_o  = (state_q == ST_DECIDE);
  assign clear_o   = capture_o || decide_o;

  // Final node when exactly two candidates remain.
  assign last_node_w = (hi_q == CLS_W'(lo_q + 1'b1));
  assign survivor_w  = score_neg_i ? hi_q : lo_q;

  always_comb begin
    pair_idx_o = PAIR_W'(pair_slot(int'(lo_q), int'(hi_q), N_CLASS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fidx_q  <= '0;
      lo_q    <= '0;
      hi_q    <= TOP_CLASS;
      done_q  <= 1'b0;
      class_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            lo_q    <= '0;
            hi_q    <= TOP_CLASS;
            fidx_q  <= '0;
            state_q <= ST_MAC;
          end
        end
        ST_MAC: begin
          if (fidx_q == LAST_FEAT) begin
            fidx_q  <= '0;
            state_q <= ST_DECIDE;
          end else begin
            fidx_q <= fidx_q + 1'b1;
          end
        end
        ST_DECIDE: begin
          if (score_neg_i) lo_q <= lo_q + 1'b1;
          else             hi_q <= hi_q - 1'b1;
          if (last_node_w) begin
            done_q  <= 1'b1;
            class_q <= survivor_w;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_MAC;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign feat_idx_o = fidx_q;
  assign lo_o       = lo_q;
  assign hi_o       = hi_q;
  assign done_o     = done_q;
  assign class_o    = class_q;
endmodule

// File: rtl/svm_dag_classifier.sv
module svm_dag_classifier #(
  parameter int unsigned N_CLASS = svm_dag_pkg::DEF_CLASSES,
  parameter int unsigned N_FEAT  = svm_dag_pkg::DEF_FEATS,
  parameter int unsigned FEAT_W  = svm_dag_pkg::DEF_FEAT_W,
  parameter int unsigned WGT_W   = svm_dag_pkg::DEF_WGT_W,
  parameter int unsigned BIAS_W  = svm_dag_pkg::DEF_BIAS_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [N_FEAT*FEAT_W-1:0]   feat_i,
  output logic                       done_o,
  output logic [$clog2(N_CLASS)-1:0] class_o
);
  localparam int unsigned CLS_W  = $clog2(N_CLASS);
  localparam int unsigned NPAIR  = N_CLASS * (N_CLASS - 1) / 2;
  localparam int unsigned PAIR_W = (NPAIR > 1) ? $clog2(NPAIR) : 1;
  localparam int unsigned FIDX_W = (N_FEAT > 1) ? $clog2(N_FEAT) : 1;
  localparam int unsigned ACC_W  = svm_dag_pkg::acc_width(FEAT_W, WGT_W, N_FEAT);

  // Named internal events, observed by the bound checker.
  logic                     busy_w, capture_w, clear_w, mac_en_w, decide_w;
  logic [FIDX_W-1:0]        fidx_w;
  logic [PAIR_W-1:0]        pair_w;
  logic [CLS_W-1:0]         lo_w, hi_w;
  logic signed [WGT_W-1:0]  wgt_w;
  logic signed [BIAS_W-1:0] bias_w;
  logic signed [ACC_W-1:0]  acc_w, score_w;
  logic                     score_neg_w;
  logic signed [FEAT_W-1:0] feat_q [N_FEAT];
  logic signed [FEAT_W-1:0] feat_sel_w;

  for (genvar gf = 0; gf < N_FEAT; gf++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         feat_q[gf] <= '0;
      else if (capture_w) feat_q[gf] <= feat_i[gf*FEAT_W +: FEAT_W];
    end
  end

  always_comb begin
    feat_sel_w = '0;
    if (int'(fidx_w) < N_FEAT) feat_sel_w = feat_q[fidx_w];
  end

  svm_dag_ctrl #(
    .N_CLASS(N_CLASS), .N_FEAT(N_FEAT), .CLS_W(CLS_W),
    .PAIR_W(PAIR_W), .FIDX_W(FIDX_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .score_neg_i(score_neg_w),
    .busy_o     (busy_w),
    .capture_o  (capture_w),
    .clear_o    (clear_w),
    .mac_en_o   (mac_en_w),
    .decide_o   (decide_w),
    .feat_idx_o (fidx_w),
    .pair_idx_o (pair_w),
    .lo_o       (lo_w),
    .hi_o       (hi_w),
    .done_o     (done_o),
    .class_o    (class_o)
  );

  svm_param_rom #(
    .N_CLASS(N_CLASS), .N_FEAT(N_FEAT), .WGT_W(WGT_W),
    .BIAS_W(BIAS_W), .PAIR_W(PAIR_W), .FIDX_W(FIDX_W)
  ) u_rom (
    .pair_idx_i(pair_w),
    .feat_idx_i(fidx_w),
    .wgt_o     (wgt_w),
    .bias_o    (bias_w)
  );

  svm_mac #(
    .FEAT_W(FEAT_W), .WGT_W(WGT_W), .BIAS_W(BIAS_W), .ACC_W(ACC_W)
  ) u_mac (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear_w),
    .mac_en_i   (mac_en_w),
    .feat_i     (feat_sel_w),
    .wgt_i      (wgt_w),
    .bias_i     (bias_w),
    .acc_o      (acc_w),
    .score_o    (score_w),
    .score_neg_o(score_neg_w)
  );
endmodule

// File: rtl/svm_dag_checker.sv
module svm_dag_checker #(
  parameter int unsigned N_CLASS = 4,
  parameter int unsigned N_FEAT  = 6,
  parameter int unsigned FEAT_W  = 8,
  parameter int unsigned WGT_W   = 8,
  parameter int unsigned BIAS_W  = 16,
  parameter int unsigned CLS_W   = 2,
  parameter int unsigned PAIR_W  = 3,
  parameter int unsigned ACC_W   = 19
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start_i,
  input logic                    busy_i,
  input logic                    decide_i,
  input logic                    score_neg_i,
  input logic [CLS_W-1:0]        lo_i,
  input logic [CLS_W-1:0]        hi_i,
  input logic [PAIR_W-1:0]       pair_i,
  input logic signed [ACC_W-1:0] acc_i,
  input logic                    done_i,
  input logic [CLS_W-1:0]        class_i
);
  localparam int NPAIR = N_CLASS * (N_CLASS - 1) / 2;
  localparam int LAT   = (N_CLASS - 1) * (N_FEAT + 1);
  localparam int BOUND = N_FEAT * (1 << (FEAT_W - 1)) * (1 << (WGT_W - 1))
                         + (1 << (BIAS_W - 1));

  int span_q, nodes_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_q  <= 0;
      nodes_q <= 0;
    end else if (start_i && !busy_i) begin
      span_q  <= 0;
      nodes_q <= 0;
    end else begin
      if (busy_i)   span_q  <= span_q + 1;
      if (decide_i) nodes_q <= nodes_q + 1;
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> span_q == LAT);

  p_pair_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> int'(pair_i) < NPAIR);

  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> lo_i < hi_i);

  p_drop_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_i && !score_neg_i) |=> (hi_i == $past(hi_i) - 1'b1) && (lo_i == $past(lo_i)));

  p_drop_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_i && score_neg_i) |=> (lo_i == $past(lo_i) + 1'b1) && (hi_i == $past(hi_i)));

  p_nodes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> nodes_q == N_CLASS - 1);

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !done_i);

  p_class_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(class_i) |-> done_i);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> ($signed(acc_i) <= BOUND) && ($signed(acc_i) >= -BOUND));

  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !decide_i && start_i) |=> busy_i && $stable(lo_i) && $stable(hi_i));
endmodule

bind svm_dag_classifier svm_dag_checker #(
  .N_CLASS(N_CLASS), .N_FEAT(N_FEAT), .FEAT_W(FEAT_W), .WGT_W(WGT_W),
  .BIAS_W(BIAS_W), .CLS_W(CLS_W), .PAIR_W(PAIR_W), .ACC_W(ACC_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_i     (busy_w),
  .decide_i   (decide_w),
  .score_neg_i(score_neg_w),
  .lo_i       (lo_w),
  .hi_i       (hi_w),
  .pair_i     (pair_w),
  .acc_i      (acc_w),
  .done_i     (done_o),
  .class_i    (class_o)
);

// File: tb/svm_dag_classifier_test.sv
module svm_dag_classifier_test;
  localparam int K   = 4;
  localparam int F   = 6;
  localparam int FW  = 8;
  localparam int LAT = (K - 1) * (F + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [F*FW-1:0] feat;
  logic          done;
  logic [1:0]    cls;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  svm_dag_classifier uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .feat_i(feat),
    .done_o(done), .class_o(cls)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pair numbering by enumeration (R2).
  function automatic int slot_of(int lo, int hi);
    int s = 0;
    for (int a = 0; a < K; a++)
      for (int b = a + 1; b < K; b++) begin
        if (a == lo && b == hi) return s;
        s++;
      end
    return -1;
  endfunction

  function automatic int w_of(int p, int f);
    return ((37 * p + 23 * f + 11) % 256) - 128;
  endfunction

  function automatic int b_of(int p);
    return (((97 * p + 13) % 256) - 128) * 64;
  endfunction

  function automatic int predict(int x[F]);
    int lo = 0;
    int hi = K - 1;
    while (lo < hi) begin
      int p = slot_of(lo, hi);
      int s = b_of(p);
      for (int f = 0; f < F; f++) s += x[f] * w_of(p, f);
      if (s >= 0) hi--; else lo++;
    end
    return lo;
  endfunction

  task automatic put(int x[F]);
    for (int f = 0; f < F; f++) feat[f*FW +: FW] = FW'(x[f]);
  endtask

  // Starts at a negedge, returns at the negedge where done is seen (or timeout).
  task automatic run(int x[F], int inject_at, output int lat);
    put(x);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (lat < 200) begin
      @(negedge clk);
      lat++;
      if (inject_at != 0 && lat == inject_at) begin
        start = 1'b1;
        for (int f = 0; f < F; f++) feat[f*FW +: FW] = FW'(-x[f] + 17);
      end else if (inject_at != 0 && lat == inject_at + 1) begin
        start = 1'b0;
      end
      if (done) break;
    end
    start = 1'b0;
  endtask

  task automatic classify(int x[F], int inject_at, string tag);
    int lat, exp_c, held;
    exp_c = predict(x);
    run(x, inject_at, lat);
    check(lat == LAT, {tag, " R1 R4 latency"}, lat, LAT);
    check(int'(cls) == exp_c, {tag, " R2 R3 class"}, int'(cls), exp_c);
    held = int'(cls);
    @(negedge clk);
    check(done == 1'b0, {tag, " R5 done width"}, int'(done), 0);
    check(int'(cls) == held, {tag, " R6 class hold"}, int'(cls), held);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 150000, LAT);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int x[F];
    int lat, c1, c2;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    start = 1'b0;
    feat  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R11 reset done", int'(done), 0);
    check(cls == 2'd0, "R11 reset class", int'(cls), 0);

    // Directed corners.
    for (int f = 0; f < F; f++) x[f] = 0;
    classify(x, 0, "zero");
    for (int f = 0; f < F; f++) x[f] = 127;
    classify(x, 0, "R7 max");
    for (int f = 0; f < F; f++) x[f] = -128;
    classify(x, 0, "R7 min");
    for (int f = 0; f < F; f++) x[f] = (f % 2 == 0) ? 127 : -128;
    classify(x, 0, "R7 alt");
    for (int f = 0; f < F; f++) x[f] = (f % 2 == 0) ? -128 : 127;
    classify(x, 0, "R7 alt2");

    // Start and feature changes while busy: R8, R9.
    for (int f = 0; f < F; f++) x[f] = 40 - 15 * f;
    classify(x, 3, "R8 R9 mid");
    for (int f = 0; f < F; f++) x[f] = -30 + 11 * f;
    classify(x, LAT - 1, "R8 R9 late");

    // Back-to-back: start in the done cycle (R10).
    for (int f = 0; f < F; f++) x[f] = 90 - 37 * f;
    c1 = predict(x);
    run(x, 0, lat);
    check(int'(cls) == c1, "R10 first class", int'(cls), c1);
    for (int f = 0; f < F; f++) x[f] = -100 + 41 * f;
    c2 = predict(x);
    put(x);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(int'(cls) == c1, "R10 R6 class held into second run", int'(cls), c1);
    lat = 0;
    while (lat < 200) begin
      @(negedge clk);
      lat++;
      if (done) break;
    end
    check(lat == LAT, "R10 R1 back-to-back latency", lat, LAT);
    check(int'(cls) == c2, "R10 R3 second class", int'(cls), c2);
    @(negedge clk);

    // Random vectors.
    for (int n = 0; n < 60; n++) begin
      for (int f = 0; f < F; f++) x[f] = int'($urandom_range(255)) - 128;
      classify(x, (n % 5 == 0) ? 1 + (n % 19) : 0, "rand");
      repeat (n % 3) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule